// File: doc/BRIEF.md
# Access Bank Address Resolver

This block turns the 8-bit file field of a byte- or bit-oriented instruction into a 12-bit data-memory address. Its inputs are the access-select bit, the 4-bit bank register, an enable for the extended instruction set, and the 12-bit value of pointer 2. It picks one of three mappings.

- **Banked direct:** the bank register supplies the upper nibble.
- **Access bank:** a low window and a high window, fixed at the bottom and top of memory.
- **Indexed with literal offset:** small access-bank file values become unsigned offsets added to pointer 2.

The block also reports which mapping it used, so the decoder and debug logic downstream can tell the cases apart. A build parameter selects a purely combinational path or a single output register. The size of data memory and the placement of the special-function region are the same whether the extended set is on or off. Only the meaning of the low access-bank file values changes.

Top module: `acc_addr_resolver`

## Requirements
- R1: With the access-select bit at 1, the address is {bank[3:0], file[7:0]} and the mode output is 0 (banked). The enable input has no effect in this case.
- R2: With access-select 0, enable 0 and file at most 5Fh, the address is {4'h0, file} and the mode output is 1 (access low).
- R3: With access-select 0 and file at 60h or above, the address is {4'hF, file} and the mode output is 2 (access high). The enable input has no effect in this case.
- R4: With access-select 0, enable 1 and file at most 5Fh, the address is pointer 2 plus the zero-extended file value, and the mode output is 3 (indexed).
- R5: The indexed sum is 12 bits wide and wraps modulo 4096. For example, pointer FF0h with offset 20h gives 010h.
- R6: The indexed window ends exactly at file 5Fh, which is indexed when enabled. File 60h is access high even when enabled.
- R7: With OUT_REG = 1, the address and mode outputs show the resolution of the inputs present at the previous rising clock edge.
- R8: With OUT_REG = 1, a synchronous active-high reset drives the address to 000h and the mode to 0 at the next edge.
- R9: With OUT_REG = 0, the outputs follow the inputs with no clock edge between, and reset has no effect on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered variant |
| rst | input | 1 | Synchronous active-high reset |
| file_i | input | 8 | File field of the instruction |
| acc_sel_i | input | 1 | Access-select bit: 0 means access bank, 1 means banked |
| bank_i | input | 4 | Bank register value |
| ext_en_i | input | 1 | Extended instruction set enable |
| ptr2_i | input | 12 | Pointer 2 base address |
| addr_o | output | 12 | Resolved data-memory address |
| mode_o | output | 2 | Mapping used: 0 banked, 1 access low, 2 access high, 3 indexed |

## Verification
The corner that is hardest to reach is the indexed sum carrying past FFFh. It only happens when the pointer sits near the top of memory and the file value lies near the 5Fh limit at the same time. The sweep covers every file value for both access-select values and both enable settings. It repeats that sweep for pointer values 000h, 123h, FF0h and FFFh, which forces wrapping offsets at both 5Fh and small values. The bank value changes with the file value so that mixed-up bank bits are exposed.

// File: rtl/acc_res_pkg.sv
package acc_res_pkg;

    localparam int unsigned FILE_W = 8;
    localparam int unsigned BANK_W = 4;
    localparam int unsigned ADDR_W = FILE_W + BANK_W;
    localparam int unsigned MODE_W = 2;

    typedef logic [FILE_W-1:0] file_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [ADDR_W-1:0] daddr_t;

    localparam bank_t LOW_PAGE  = '0;
    localparam bank_t HIGH_PAGE = '1;

    typedef enum logic [MODE_W-1:0] {
        AM_BANKED   = 2'd0,
        AM_ACC_LOW  = 2'd1,
        AM_ACC_HIGH = 2'd2,
        AM_INDEXED  = 2'd3
    } amode_e;

    typedef struct packed {
        file_t  file;
        logic   acc_sel;
        bank_t  bank;
        logic   ext_en;
        daddr_t ptr;
    } req_t;

    typedef struct packed {
        daddr_t addr;
        amode_e mode;
    } resolved_t;

    function automatic daddr_t banked_addr(bank_t b, file_t f);
        return {b, f};
    endfunction

    function automatic daddr_t paged_addr(bank_t page, file_t f);
        return {page, f};
    endfunction

    function automatic daddr_t offset_addr(daddr_t base, file_t f);
        daddr_t ext;
        ext = {{BANK_W{1'b0}}, f};
        return base + ext;
    endfunction

endpackage

// File: rtl/arb_mode_sel.sv
module arb_mode_sel
    import acc_res_pkg::*;
#(
    parameter file_t IDX_LIMIT = 8'h5F
) (
    input  req_t   req,
    output amode_e mode
);
    logic in_low_window;

    assign in_low_window = (req.file <= IDX_LIMIT);

    always_comb begin
        if (req.acc_sel)
            mode = AM_BANKED;
        else if (!in_low_window)
            mode = AM_ACC_HIGH;
        else if (req.ext_en)
            mode = AM_INDEXED;
        else
            mode = AM_ACC_LOW;
    end
endmodule

// File: rtl/arb_addr_gen.sv
module arb_addr_gen
    import acc_res_pkg::*;
(
    input  req_t      req,
    input  amode_e    mode,
    output resolved_t res
);
    daddr_t cand_bank;
    daddr_t cand_low;
    daddr_t cand_high;
    daddr_t cand_idx;

    assign cand_bank = banked_addr(req.bank, req.file);
    assign cand_low  = paged_addr(LOW_PAGE, req.file);
    assign cand_high = paged_addr(HIGH_PAGE, req.file);
    assign cand_idx  = offset_addr(req.ptr, req.file);

    always_comb begin
        res.mode = mode;
        unique case (mode)
            AM_BANKED:   res.addr = cand_bank;
            AM_ACC_LOW:  res.addr = cand_low;
            AM_ACC_HIGH: res.addr = cand_high;
            AM_INDEXED:  res.addr = cand_idx;
            default:     res.addr = cand_bank;
        endcase
    end
endmodule

// File: rtl/arb_out_stage.sv
module arb_out_stage
    import acc_res_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  resolved_t d,
    output resolved_t q
);
    generate
        if (OUT_REG) begin : g_reg
            resolved_t q_r;
            always_ff @(posedge clk) begin
                if (rst)
                    q_r <= '{addr: '0, mode: AM_BANKED};
                else
                    q_r <= d;
            end
            assign q = q_r;
        end else begin : g_comb
            logic unused_ok;
            assign unused_ok = clk ^ rst;
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/acc_addr_resolver.sv
module acc_addr_resolver
    import acc_res_pkg::*;
#(
    parameter bit    OUT_REG   = 1'b1,
    parameter file_t IDX_LIMIT = 8'h5F
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  file_i,
    input  logic        acc_sel_i,
    input  logic [3:0]  bank_i,
    input  logic        ext_en_i,
    input  logic [11:0] ptr2_i,
    output logic [11:0] addr_o,
    output logic [1:0]  mode_o
);
    req_t      req;
    amode_e    mode_c;
    resolved_t res_c;
    resolved_t res_q;

    assign req = '{file: file_i, acc_sel: acc_sel_i, bank: bank_i,
                   ext_en: ext_en_i, ptr: ptr2_i};

    arb_mode_sel #(.IDX_LIMIT(IDX_LIMIT)) u_sel (
        .req  (req),
        .mode (mode_c)
    );

    arb_addr_gen u_gen (
        .req  (req),
        .mode (mode_c),
        .res  (res_c)
    );

    arb_out_stage #(.OUT_REG(OUT_REG)) u_out (
        .clk (clk),
        .rst (rst),
        .d   (res_c),
        .q   (res_q)
    );

    assign addr_o = res_q.addr;
    assign mode_o = res_q.mode;

    // R1: banked path uses the bank nibble, whatever the enable
    p_banked_r1: assert property (@(posedge clk) disable iff (rst)
        acc_sel_i |-> (res_c.mode == AM_BANKED && res_c.addr[11:8] == bank_i
                       && res_c.addr[7:0] == file_i));

    // R3: high window always lands on the top page
    p_high_page_r3: assert property (@(posedge clk) disable iff (rst)
        (!acc_sel_i && file_i > IDX_LIMIT) |-> (res_c.addr[11:8] == HIGH_PAGE
                                              && res_c.mode == AM_ACC_HIGH));

    // R4: indexed mode only under its three conditions
    p_indexed_cond_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_c == AM_INDEXED) |-> (ext_en_i && !acc_sel_i && file_i <= IDX_LIMIT));

    // R2: enable low and low window gives the bottom page
    p_low_page_r2: assert property (@(posedge clk) disable iff (rst)
        (!acc_sel_i && !ext_en_i && file_i <= IDX_LIMIT) |->
        (res_c.addr[11:8] == LOW_PAGE && res_c.mode == AM_ACC_LOW));

    generate
        if (OUT_REG) begin : g_reg_chk
            // R7: one cycle of latency
            p_latency_r7: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (addr_o == $past(res_c.addr) && mode_o == $past(res_c.mode)));
            // R8: reset clears the outputs
            p_reset_r8: assert property (@(posedge clk)
                rst |=> (addr_o == 12'h000 && mode_o == 2'd0));
        end else begin : g_comb_chk
            // R9: outputs track the resolver directly
            p_comb_r9: assert property (@(posedge clk)
                addr_o == res_c.addr);
        end
    endgenerate
endmodule

// File: tb/acc_addr_resolver_test.sv
`timescale 1ns/1ps
module acc_addr_resolver_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  file_i = 8'h55;
    logic        acc_sel_i = 1'b1;
    logic [3:0]  bank_i = 4'hA;
    logic        ext_en_i = 1'b0;
    logic [11:0] ptr2_i = 12'h000;
    logic [11:0] addr_r, addr_c;
    logic [1:0]  mode_r, mode_c;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    acc_addr_resolver #(.OUT_REG(1'b1)) uut (
        .clk(clk), .rst(rst), .file_i(file_i), .acc_sel_i(acc_sel_i),
        .bank_i(bank_i), .ext_en_i(ext_en_i), .ptr2_i(ptr2_i),
        .addr_o(addr_r), .mode_o(mode_r));

    acc_addr_resolver #(.OUT_REG(1'b0)) uut_comb (
        .clk(clk), .rst(rst), .file_i(file_i), .acc_sel_i(acc_sel_i),
        .bank_i(bank_i), .ext_en_i(ext_en_i), .ptr2_i(ptr2_i),
        .addr_o(addr_c), .mode_o(mode_c));

    function automatic logic [13:0] model(logic en, logic a, logic [7:0] f,
                                          logic [3:0] b, logic [11:0] p);
        int sum;
        if (a) return {2'd0, b, f};
        if (f >= 8'h60) return {2'd2, 4'hF, f};
        if (!en) return {2'd1, 4'h0, f};
        sum = (int'(p) + int'(f)) % 4096;
        return {2'd3, 12'(sum)};
    endfunction

    task automatic check(string tag, logic [13:0] got, logic [13:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got mode=%0d addr=%03h expected mode=%0d addr=%03h",
                     tag, got[13:12], got[11:0], exp[13:12], exp[11:0]);
        end
    endtask

    function automatic string tag_of(logic en, logic a, logic [7:0] f,
                                     logic [11:0] p);
        if (a) return "R1";
        if (f >= 8'h60) return (f == 8'h60) ? "R6" : "R3";
        if (!en) return "R2";
        if (f == 8'h5F) return "R6";
        if (int'(p) + int'(f) > 4095) return "R5";
        return "R4";
    endfunction

    initial begin
        logic [11:0] ptrs [4];
        logic [13:0] exp;
        ptrs[0] = 12'h000; ptrs[1] = 12'h123; ptrs[2] = 12'hFF0; ptrs[3] = 12'hFFF;
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset", {mode_r, addr_r}, 14'h0000);
        check("R9 comb under reset", {mode_c, addr_c}, {2'd0, 12'hA55});
        @(negedge clk);
        rst = 1'b0;
        for (int pi = 0; pi < 4; pi++) begin
            for (int en = 0; en < 2; en++) begin
                for (int a = 0; a < 2; a++) begin
                    for (int f = 0; f < 256; f++) begin
                        @(negedge clk);
                        file_i    = 8'(f);
                        acc_sel_i = a[0];
                        ext_en_i  = en[0];
                        ptr2_i    = ptrs[pi];
                        bank_i    = 4'(f * 7 + pi);
                        exp = model(en[0], a[0], 8'(f), bank_i, ptrs[pi]);
                        #1;
                        check({tag_of(en[0], a[0], 8'(f), ptrs[pi]), " R9 comb"},
                              {mode_c, addr_c}, exp);
                        @(posedge clk);
                        #1;
                        check({tag_of(en[0], a[0], 8'(f), ptrs[pi]), " R7 reg"},
                              {mode_r, addr_r}, exp);
                    end
                end
            end
        end
        @(negedge clk);
        ext_en_i = 1'b1; acc_sel_i = 1'b0; ptr2_i = 12'hFF0; file_i = 8'h20;
        #1;
        check("R5 wrap", {mode_c, addr_c}, {2'd3, 12'h010});
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule